// File: doc/BRIEF.md
# Word FIFO Pair for an I2C Byte Engine

This block connects a 32-bit register bus to a byte-wide I2C engine. Words written by software go into a transmit FIFO. The engine takes them one byte at a time, low byte first. Bytes that the engine receives are packed into words in the same order and go into a receive FIFO, from which software reads them. One control register holds the two trigger levels and two self-clearing flush bits. A status register gives the number of free transmit slots and the number of receive words waiting.

A transfer's length need not be a multiple of four. On the transmit side, the engine marks the final byte of a transfer, and the word that holds it is retired at once; its remaining bytes are never sent. On the receive side, a final-byte mark pushes the partly filled word as a whole word, with its unused bytes zero. Two level outputs ask the interrupt logic for service: transmit when free space exceeds its trigger level, and receive when stored words exceed theirs. A write to a full transmit FIFO or a read from an empty receive FIFO is dropped, and a one-cycle pulse reports it.

Top module: `i2c_wfifo_pair`

## Requirements
- R1: After synchronous reset both FIFOs are empty. The status register reads 0x80 (8 free transmit slots, 0 receive words), the control register reads 0, and neither error pulse is high.
- R2: Register select 1 (status) returns the free transmit slot count (DEPTH minus occupancy) in bits 7:4 and the receive occupancy in bits 3:0, with all other bits zero.
- R3: Register select 0 (control) holds the transmit trigger level in bits 7:5, the receive trigger level in bits 4:2, the transmit flush in bit 1 and the receive flush in bit 0, and reads back in the same layout. Register select 2 reads as zero.
- R4: A control write with a flush bit set makes that bit read back as 1 for exactly one cycle. At the next clock edge that FIFO and its byte position or partial word are cleared, and the bit then reads 0. A flush wins over a push or pop in the same cycle.
- R5: The transmit byte output shows the head word's bytes in the order bits 7:0, 15:8, 23:16, 31:24, advancing on each accepted take. The byte-valid output is high whenever the transmit FIFO holds a word.
- R6: A take with the final-byte mark retires the head word immediately, whatever its byte position. The next byte offered is byte 0 of the following word.
- R7: Received bytes fill a word from bits 7:0 upward. The fourth byte pushes the word. Register select 3 shows the oldest receive word, and a bus read of it pops it.
- R8: A received byte carrying the final-byte mark pushes the partial word at once, with the unfilled upper bytes zero.
- R9: The transmit request is high exactly when free transmit slots exceed the transmit trigger level. The receive request is high exactly when stored receive words exceed the receive trigger level.
- R10: A write to select 2 while the transmit FIFO is full is dropped, and the overflow output pulses high in the following cycle.
- R11: A read of select 3 while the receive FIFO is empty returns zero, changes nothing, and the underflow output pulses high in the following cycle.
- R12: A push and a pop on the same FIFO in one cycle leave its occupancy unchanged and keep word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at select 3) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| eng_tx_byte | output | 8 | Current transmit byte offered to the engine |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_tx_last | input | 1 | The consumed byte is the final one of the transfer |
| eng_rx_byte | input | 8 | Received byte from the engine |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_last | input | 1 | The received byte is the final one of the transfer |
| tx_req | output | 1 | Transmit data request level |
| rx_req | output | 1 | Receive data request level |
| tx_overflow | output | 1 | One-cycle pulse after a dropped transmit write |
| rx_underflow | output | 1 | One-cycle pulse after a read of an empty receive FIFO |

## Verification
On each FIFO, a push from one side and a pop from the other can fall in the same cycle. A flush can also land in the cycle where a push or pop arrives. The bench forces both cases on purpose: a bus write to the transmit data register together with a final-byte take, a completed receive word together with a bus read, and a received byte in the very cycle a flush is pending. It judges each by the status occupancy in the next cycle and by the words that come out afterwards. A behavioural queue model, compared on every clock, checks the same collisions again during a long random phase.

// File: rtl/i2c_wfifo_pkg.sv
package i2c_wfifo_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int TRIG_W = 3;
    localparam int ADDR_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;

    // bit order follows the control register layout, MSB first
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_flush;
        logic              rx_flush;
    } fifo_ctrl_t;

    localparam int CTRL_W = $bits(fifo_ctrl_t);

    function automatic byte_t lane_get(word_t w, lane_t l);
        return w[int'(l)*BYTE_W +: BYTE_W];
    endfunction

    function automatic word_t lane_put(word_t w, lane_t l, byte_t b);
        word_t r;
        r = w;
        r[int'(l)*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

    function automatic logic lane_is_top(lane_t l);
        return l == lane_t'(LANES - 1);
    endfunction

endpackage

// File: rtl/i2c_wfifo_store.sv
module i2c_wfifo_store
    import i2c_wfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  word_t            push_word,
    input  logic             pop,
    output word_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem[wr_ptr] <= push_word;
        end
    end

endmodule

// File: rtl/i2c_wfifo_unpack.sv
module i2c_wfifo_unpack
    import i2c_wfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  word_t head,
    input  logic  avail,
    input  logic  take,
    input  logic  last,
    output byte_t out_byte,
    output logic  out_valid,
    output logic  pop
);

    lane_t lane;
    logic  fire;

    assign out_valid = avail;
    assign out_byte  = lane_get(head, lane);
    assign fire      = take && avail;
    assign pop       = fire && (lane_is_top(lane) || last);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lane <= '0;
        end else if (fire) begin
            lane <= pop ? '0 : lane + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_wfifo_pack.sv
module i2c_wfifo_pack
    import i2c_wfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  logic  in_last,
    output logic  push,
    output word_t push_word
);

    word_t acc;
    lane_t lane;
    word_t merged;

    assign merged    = lane_put(acc, lane, in_byte);
    assign push      = in_valid && (lane_is_top(lane) || in_last);
    assign push_word = merged;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc  <= '0;
            lane <= '0;
        end else if (in_valid) begin
            if (push) begin
                acc  <= '0;
                lane <= '0;
            end else begin
                acc  <= merged;
                lane <= lane + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_wfifo_regs.sv
module i2c_wfifo_regs
    import i2c_wfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  word_t             rx_head,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              tx_push,
    output logic              rx_pop,
    output word_t             bus_rdata,
    output logic              tx_req,
    output logic              rx_req,
    output logic              tx_overflow,
    output logic              rx_underflow
);

    fifo_ctrl_t       ctrl_q;
    reg_sel_e         sel;
    logic             ctrl_wr;
    logic [CNT_W-1:0] tx_free;

    assign sel     = reg_sel_e'(bus_addr);
    assign ctrl_wr = bus_wr && (sel == REG_CTRL);
    assign tx_push = bus_wr && (sel == REG_TXD);
    assign rx_pop  = bus_rd && (sel == REG_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= fifo_ctrl_t'(ctrl_wdata);
        end else begin
            ctrl_q.tx_flush <= 1'b0;
            ctrl_q.rx_flush <= 1'b0;
        end
    end

    assign tx_flush = ctrl_q.tx_flush;
    assign rx_flush = ctrl_q.rx_flush;

    assign tx_free = CNT_W'(DEPTH) - tx_count;
    assign tx_req  = tx_free > CNT_W'(ctrl_q.tx_trig);
    assign rx_req  = rx_count > CNT_W'(ctrl_q.rx_trig);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_CTRL: bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
            REG_STAT: bus_rdata = {{(WORD_W-2*CNT_W){1'b0}}, tx_free, rx_count};
            REG_TXD:  bus_rdata = '0;
            REG_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            tx_overflow  <= tx_push && tx_full;
            rx_underflow <= rx_pop && rx_empty;
        end
    end

endmodule

// File: rtl/i2c_wfifo_pair.sv
module i2c_wfifo_pair
    import i2c_wfifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [i2c_wfifo_pkg::ADDR_W-1:0]    bus_addr,
    input  logic [i2c_wfifo_pkg::WORD_W-1:0]    bus_wdata,
    output logic [i2c_wfifo_pkg::WORD_W-1:0]    bus_rdata,
    output logic [i2c_wfifo_pkg::BYTE_W-1:0]    eng_tx_byte,
    output logic                                eng_tx_valid,
    input  logic                                eng_tx_take,
    input  logic                                eng_tx_last,
    input  logic [i2c_wfifo_pkg::BYTE_W-1:0]    eng_rx_byte,
    input  logic                                eng_rx_valid,
    input  logic                                eng_rx_last,
    output logic                                tx_req,
    output logic                                rx_req,
    output logic                                tx_overflow,
    output logic                                rx_underflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             tx_flush, rx_flush;
    logic             tx_push, tx_pop;
    logic             rx_push, rx_pop;
    word_t            tx_head, rx_head, rx_word;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    i2c_wfifo_regs #(.DEPTH(DEPTH)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .ctrl_wdata   (bus_wdata[CTRL_W-1:0]),
        .tx_count     (tx_count),
        .rx_count     (rx_count),
        .tx_full      (tx_full),
        .rx_empty     (rx_empty),
        .rx_head      (rx_head),
        .tx_flush     (tx_flush),
        .rx_flush     (rx_flush),
        .tx_push      (tx_push),
        .rx_pop       (rx_pop),
        .bus_rdata    (bus_rdata),
        .tx_req       (tx_req),
        .rx_req       (rx_req),
        .tx_overflow  (tx_overflow),
        .rx_underflow (rx_underflow)
    );

    i2c_wfifo_store #(.DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_word (bus_wdata),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    i2c_wfifo_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .head      (tx_head),
        .avail     (!tx_empty),
        .take      (eng_tx_take),
        .last      (eng_tx_last),
        .out_byte  (eng_tx_byte),
        .out_valid (eng_tx_valid),
        .pop       (tx_pop)
    );

    i2c_wfifo_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .in_valid  (eng_rx_valid),
        .in_byte   (eng_rx_byte),
        .in_last   (eng_rx_last),
        .push      (rx_push),
        .push_word (rx_word)
    );

    i2c_wfifo_store #(.DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_word (rx_word),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

endmodule

// File: rtl/i2c_wfifo_pair_chk.sv
module i2c_wfifo_pair_chk
    import i2c_wfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_flush,
    input logic              rx_flush,
    input logic              tx_pop,
    input logic              tx_req,
    input logic              rx_req,
    input logic              tx_overflow,
    input logic              rx_underflow
);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $fell(rst) |-> (tx_count == '0 && rx_count == '0 && !tx_overflow && !rx_underflow)); // R1

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH))); // R2

    AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_count == '0)); // R4

    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_count == '0)); // R4

    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((tx_flush || rx_flush) && !(bus_wr && bus_addr == REG_CTRL)) |=> (!tx_flush && !rx_flush)); // R4

    AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_TXD && tx_full) |=> tx_overflow); // R10

    AST_NO_SPURIOUS_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |-> $past(bus_wr && bus_addr == REG_TXD && tx_full)); // R10

    AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_RXD && rx_empty) |=> rx_underflow); // R11

    AST_EMPTY_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> !rx_req); // R9

    AST_TX_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_TXD && !tx_full && tx_pop && !tx_flush) |=> $stable(tx_count)); // R12

    generate
        if (DEPTH > (2**TRIG_W) - 1) begin : g_deep
            AST_EMPTY_TX_REQ: assert property (@(posedge clk) disable iff (rst)
                (tx_count == '0) |-> tx_req); // R9
        end
    endgenerate

endmodule

bind i2c_wfifo_pair i2c_wfifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_full      (tx_full),
    .rx_empty     (rx_empty),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .tx_pop       (tx_pop),
    .tx_req       (tx_req),
    .rx_req       (rx_req),
    .tx_overflow  (tx_overflow),
    .rx_underflow (rx_underflow)
);

// File: tb/i2c_wfifo_pair_tb.sv
module i2c_wfifo_pair_tb;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_valid;
    logic        eng_tx_take = 1'b0, eng_tx_last = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_valid = 1'b0, eng_rx_last = 1'b0;
    logic        tx_req, rx_req, tx_overflow, rx_underflow;

    i2c_wfifo_pair #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_byte(eng_tx_byte),
        .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take), .eng_tx_last(eng_tx_last),
        .eng_rx_byte(eng_rx_byte), .eng_rx_valid(eng_rx_valid), .eng_rx_last(eng_rx_last),
        .tx_req(tx_req), .rx_req(rx_req), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit rst_drive = 1'b1;

    // behavioural reference model
    logic [31:0] mtx[$];
    logic [31:0] mrx[$];
    int          mtx_idx = 0;
    int          mrx_idx = 0;
    logic [31:0] macc = '0;
    logic [2:0]  mtt = '0, mrt = '0;
    bit          mtp = 0, mrp = 0, movf = 0, munf = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {24'd0, mtt, mrt, mtp, mrp};
            2'd1:    return {24'd0, 4'(DEPTH - mtx.size()), 4'(mrx.size())};
            2'd2:    return 32'd0;
            default: return (mrx.size() > 0) ? mrx[0] : 32'd0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] hw;
        string tag;
        case (bus_addr)
            2'd0: tag = "R3";
            2'd1: tag = "R2";
            2'd2: tag = "R3";
            default: tag = "R7";
        endcase
        check(bus_rdata, exp_rdata(bus_addr), tag);
        check(32'(eng_tx_valid), 32'(mtx.size() > 0), "R5");
        if (mtx.size() > 0) begin
            hw = mtx[0];
            check(32'(eng_tx_byte), 32'(hw[mtx_idx*8 +: 8]), "R5");
        end
        check(32'(tx_req), 32'((DEPTH - mtx.size()) > int'(mtt)), "R9");
        check(32'(rx_req), 32'(mrx.size() > int'(mrt)), "R9");
        check(32'(tx_overflow), 32'(movf), "R10");
        check(32'(rx_underflow), 32'(munf), "R11");
    endtask

    task automatic model_update();
        int  txn, rxn;
        bit  tpop, tpush, rpop, rpush;
        logic [31:0] w;
        txn = mtx.size();
        rxn = mrx.size();
        if (rst) begin
            mtx.delete(); mrx.delete();
            mtx_idx = 0; mrx_idx = 0; macc = '0;
            mtt = '0; mrt = '0; mtp = 0; mrp = 0; movf = 0; munf = 0;
            return;
        end
        movf = bus_wr && bus_addr == 2'd2 && txn == DEPTH;
        munf = bus_rd && bus_addr == 2'd3 && rxn == 0;
        // transmit side
        if (mtp) begin
            mtx.delete(); mtx_idx = 0;
        end else begin
            tpush = bus_wr && bus_addr == 2'd2 && txn < DEPTH;
            tpop  = eng_tx_take && txn > 0 && (mtx_idx == 3 || eng_tx_last);
            if (eng_tx_take && txn > 0) mtx_idx = tpop ? 0 : mtx_idx + 1;
            if (tpop) void'(mtx.pop_front());
            if (tpush) mtx.push_back(bus_wdata);
        end
        // receive side
        if (mrp) begin
            mrx.delete(); mrx_idx = 0; macc = '0;
        end else begin
            rpop  = bus_rd && bus_addr == 2'd3 && rxn > 0;
            rpush = 0;
            w     = macc;
            if (eng_rx_valid) begin
                w[mrx_idx*8 +: 8] = eng_rx_byte;
                if (mrx_idx == 3 || eng_rx_last) begin
                    rpush = (rxn < DEPTH);
                    macc = '0; mrx_idx = 0;
                end else begin
                    macc = w; mrx_idx++;
                end
            end
            if (rpop) void'(mrx.pop_front());
            if (rpush) mrx.push_back(w);
        end
        // control register
        if (bus_wr && bus_addr == 2'd0) begin
            mtt = bus_wdata[7:5]; mrt = bus_wdata[4:2];
            mtp = bus_wdata[1];   mrp = bus_wdata[0];
        end else begin
            mtp = 0; mrp = 0;
        end
    endtask

    task automatic cycle(input bit wr = 0, input bit rd = 0, input logic [1:0] addr = 2'd1,
                         input logic [31:0] wd = 0, input bit take = 0, input bit tlast = 0,
                         input bit rv = 0, input logic [7:0] rb = 0, input bit rl = 0,
                         input bit ce = 0, input logic [31:0] ce_exp = 0, input string ce_tag = "");
        @(negedge clk);
        rst = rst_drive;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        eng_tx_take = take; eng_tx_last = tlast;
        eng_rx_valid = rv; eng_rx_byte = rb; eng_rx_last = rl;
        #1;
        if (!rst) begin
            compare();
            if (ce) check(bus_rdata, ce_exp, ce_tag);
        end
        @(posedge clk);
        model_update();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst_drive = 1'b0;
        // R1 reset state
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h80), .ce_tag("R1"));
        cycle(.addr(2'd0), .ce(1), .ce_exp(32'h00), .ce_tag("R1"));
        // R3 trigger levels: tx 3, rx 1
        cycle(.wr(1), .addr(2'd0), .wd(32'h64));
        cycle(.addr(2'd0), .ce(1), .ce_exp(32'h64), .ce_tag("R3"));
        // fill transmit FIFO, then overflow (R10)
        for (int i = 0; i < DEPTH; i++) cycle(.wr(1), .addr(2'd2), .wd(32'hA0B1C2D3 + 32'(i) * 32'h01010101));
        cycle(.wr(1), .addr(2'd2), .wd(32'hDEADBEEF));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h00), .ce_tag("R10"));
        // R5 drain first word byte by byte
        for (int i = 0; i < 4; i++) cycle(.take(1));
        // R6 early last retires word 1 after two bytes
        cycle(.take(1));
        cycle(.take(1), .tlast(1));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h20), .ce_tag("R6"));
        // R4 transmit flush
        cycle(.wr(1), .addr(2'd0), .wd(32'h66));
        cycle(.addr(2'd0), .ce(1), .ce_exp(32'h66), .ce_tag("R4"));
        cycle(.addr(2'd0), .ce(1), .ce_exp(32'h64), .ce_tag("R4"));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h80), .ce_tag("R4"));
        // R7 and R8 receive packing
        for (int i = 1; i <= 4; i++) cycle(.rv(1), .rb(8'(i)));
        cycle(.rv(1), .rb(8'h05));
        cycle(.rv(1), .rb(8'h06), .rl(1));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h82), .ce_tag("R7"));
        cycle(.addr(2'd3), .ce(1), .ce_exp(32'h04030201), .ce_tag("R7"));
        cycle(.rd(1), .addr(2'd3));
        cycle(.addr(2'd3), .ce(1), .ce_exp(32'h00000605), .ce_tag("R8"));
        cycle(.rd(1), .addr(2'd3));
        // R11 underflow
        cycle(.rd(1), .addr(2'd3), .ce(1), .ce_exp(32'h0), .ce_tag("R11"));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h80), .ce_tag("R11"));
        // R12 same-cycle push and pop, transmit
        cycle(.wr(1), .addr(2'd2), .wd(32'h11111111));
        cycle(.wr(1), .addr(2'd2), .wd(32'h22222222));
        cycle(.wr(1), .addr(2'd2), .wd(32'h33333333), .take(1), .tlast(1));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h60), .ce_tag("R12"));
        // R12 same-cycle push and pop, receive
        cycle(.rv(1), .rb(8'hAA), .rl(1));
        cycle(.rv(1), .rb(8'hBB), .rl(1), .rd(1), .addr(2'd3));
        cycle(.addr(2'd3), .ce(1), .ce_exp(32'h000000BB), .ce_tag("R12"));
        // R4 flush collides with a receive push
        cycle(.wr(1), .addr(2'd0), .wd(32'h65));
        cycle(.rv(1), .rb(8'hCC), .rl(1));
        cycle(.addr(2'd1), .ce(1), .ce_exp(32'h60), .ce_tag("R4"));
        // random phase, model compared every clock
        for (int i = 0; i < 4000; i++) begin
            int  r;
            bit  w, rd;
            logic [1:0] a;
            logic [31:0] d;
            r  = $urandom_range(0, 99);
            a  = 2'($urandom_range(0, 3));
            w  = (r < 30);
            rd = (r >= 30 && r < 55);
            d  = $urandom();
            if (w && a == 2'd0 && $urandom_range(0, 3) != 0) d[1:0] = 2'b00;
            if (w && a == 2'd0 && $urandom_range(0, 1) == 0) a = 2'd2;
            cycle(.wr(w), .rd(rd), .addr(a), .wd(d),
                  .take($urandom_range(0, 1) == 1), .tlast($urandom_range(0, 5) == 0),
                  .rv($urandom_range(0, 2) == 0), .rb(8'($urandom())), .rl($urandom_range(0, 6) == 0));
        end
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule